// File: doc/BRIEF.md
# Slow Clock Calibration Counter

This block measures a slow, low-frequency clock against the fast reference clock it runs on. One of three slow sources is picked by a select field. The picked source passes through a two-flop synchroniser, and its rising edges are detected in the reference domain. After an arming edge, the block counts reference cycles until a programmed number of further slow edges has been seen. The final count is the calibration result. Software converts that result into a period or a frequency.

A measurement runs once when the start bit goes from 0 to 1. When cycling is enabled, measurements repeat back to back, and the edge that closes one window opens the next. Cycling is the mode in effect out of reset. A hardware timeout guards every measurement. The reference cycles since the start are compared against the threshold multiplied by the slow-cycle count. When that limit is reached first, the measurement is abandoned, the counters are cleared and a timeout flag is raised. Writing a threshold of 1 therefore ends a stalled measurement almost at once.

Top module: `slowcal_top`

## Requirements
- R1: After reset, the control word (address 0) reads cycle-enable (bit 3) as 1, ready (bit 4) as 0 and timeout (bit 5) as 0. The slow-count register (address 1) reads 8, the threshold register (address 2) reads 0xFFFF, and the result (address 3) reads 0.
- R2: With cycling off, a measurement over N slow cycles of a clock whose rising edges are P reference cycles apart sets ready and leaves N*P in the result.
- R3: A measurement starts only when a write to address 0 moves the start bit (bit 2) from 0 to 1. Writing 1 while the stored bit is already 1 leaves the ready flag and the result unchanged.
- R4: A start edge clears both the ready flag and the timeout flag on the next clock edge.
- R5: After a single measurement completes with cycling off, the block goes idle (bit 6, busy, reads 0). The result does not change afterwards, even when the slow clock changes.
- R6: With cycling on (out of reset or via bit 3), measurements repeat, and the result follows a change of the slow clock's period.
- R7: Bits 1:0 of address 0 select slow source 0, 1 or 2. The value 3 selects no source, which is a constant-low input.
- R8: When the measurement has not finished T*N reference cycles after the start edge (T is the threshold, N the slow count), the timeout flag is set on exactly that edge. Ready is then 0, the result reads 0, and the block goes idle without restarting.
- R9: After a timeout, the next start edge runs a clean measurement that yields the correct count.
- R10: Lowering the threshold to 1 during a running cycling measurement raises the timeout on the next clock edge, and the block stops.
- R11: A slow count of 0 behaves as a count of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slow_src_i | input | NSRC | Slow clock sources, sampled in the reference domain |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | DATA_W | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | DATA_W | Combinational read data |

## Verification
The timeout flag is due exactly T*N edges after the edge that captures the start write. The bench checks it as clear one cycle before that and as set on that cycle. Flag clearing after a start edge, and the timeout caused by lowering the threshold, are due one edge after the write, and the bench samples them at the next falling edge. Ready rises one edge after the synchronised closing slow edge. The bench does not predict the synchroniser phase. It polls ready at falling edges with a bound of (N+1)*P plus a margin, and then compares the exact count, which does not depend on the synchroniser delay.

// File: rtl/slowcal_pkg.sv
package slowcal_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARM   = 2'd1,
        ST_COUNT = 2'd2
    } cal_state_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_MAX  = 2'd1;
    localparam logic [1:0] ADDR_THR  = 2'd2;
    localparam logic [1:0] ADDR_RES  = 2'd3;

    localparam int CTRL_START = 2;
    localparam int CTRL_CYC   = 3;
    localparam int CTRL_RDY   = 4;
    localparam int CTRL_TO    = 5;
    localparam int CTRL_BUSY  = 6;

endpackage

// File: rtl/slowcal_sync.sv
module slowcal_sync #(
    parameter int NSRC  = 3,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  src_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             rise_o
);

    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t q, d;
    logic  picked;

    // source mux; an unused select code yields a constant low input
    always_comb begin
        picked = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (sel_i == SEL_W'(i)) picked = src_i[i];
        end
    end

    always_comb begin
        d    = q;
        d.s1 = picked;
        d.s2 = q.s1;
        d.s3 = q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rise_o = q.s2 & ~q.s3;

endmodule

// File: rtl/slowcal_regs.sv
module slowcal_regs
    import slowcal_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int SEL_W   = 2,
    parameter int CNT_W   = 10,
    parameter int THR_W   = 16,
    parameter int RES_W   = 26,
    parameter int RST_MAX = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [1:0]        rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic              ready_i,
    input  logic              timeout_i,
    input  logic              busy_i,
    input  logic [RES_W-1:0]  result_i,
    output logic [SEL_W-1:0]  sel_o,
    output logic [CNT_W-1:0]  max_o,
    output logic [THR_W-1:0]  thr_o,
    output logic              cyc_en_o,
    output logic              start_pulse_o
);

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             start;
        logic             cyc;
        logic [CNT_W-1:0] maxc;
        logic [THR_W-1:0] thr;
    } regs_t;

    regs_t q, d;
    logic  ctrl_wr;

    always_comb begin
        d       = q;
        ctrl_wr = wr_en_i && (wr_addr_i == ADDR_CTRL);
        if (ctrl_wr) begin
            d.sel   = wr_data_i[SEL_W-1:0];
            d.start = wr_data_i[CTRL_START];
            d.cyc   = wr_data_i[CTRL_CYC];
        end
        if (wr_en_i && (wr_addr_i == ADDR_MAX)) d.maxc = wr_data_i[CNT_W-1:0];
        if (wr_en_i && (wr_addr_i == ADDR_THR)) d.thr  = wr_data_i[THR_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.sel   <= '0;
            q.start <= 1'b0;
            q.cyc   <= 1'b1;
            q.maxc  <= CNT_W'(RST_MAX);
            q.thr   <= '1;
        end else begin
            q <= d;
        end
    end

    // a start request is only a 0-to-1 move of the stored bit
    assign start_pulse_o = ctrl_wr && wr_data_i[CTRL_START] && !q.start;

    assign sel_o    = q.sel;
    assign max_o    = q.maxc;
    assign thr_o    = q.thr;
    assign cyc_en_o = q.cyc;

    always_comb begin
        rd_data_o = '0;
        unique case (rd_addr_i)
            ADDR_CTRL: begin
                rd_data_o[SEL_W-1:0]  = q.sel;
                rd_data_o[CTRL_START] = q.start;
                rd_data_o[CTRL_CYC]   = q.cyc;
                rd_data_o[CTRL_RDY]   = ready_i;
                rd_data_o[CTRL_TO]    = timeout_i;
                rd_data_o[CTRL_BUSY]  = busy_i;
            end
            ADDR_MAX: rd_data_o[CNT_W-1:0] = q.maxc;
            ADDR_THR: rd_data_o[THR_W-1:0] = q.thr;
            ADDR_RES: rd_data_o[RES_W-1:0] = timeout_i ? '0 : result_i;
            default:  rd_data_o = '0;
        endcase
    end

endmodule

// File: rtl/slowcal_engine.sv
module slowcal_engine
    import slowcal_pkg::*;
#(
    parameter int CNT_W = 10,
    parameter int THR_W = 16,
    localparam int TCNT_W = CNT_W + THR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_i,
    input  logic              start_pulse_i,
    input  logic              cyc_en_i,
    input  logic [CNT_W-1:0]  max_i,
    input  logic [THR_W-1:0]  thr_i,
    output logic              ready_o,
    output logic              timeout_o,
    output logic              busy_o,
    output logic [TCNT_W-1:0] result_o
);

    typedef struct packed {
        cal_state_e        st;
        logic              ready;
        logic              timeout;
        logic [CNT_W-1:0]  scnt;
        logic [TCNT_W-1:0] rcnt;
        logic [TCNT_W-1:0] tcnt;
        logic [TCNT_W-1:0] result;
    } eng_t;

    eng_t q, d;

    logic [CNT_W-1:0]  eff_max;
    logic [CNT_W-1:0]  scnt_inc;
    logic [TCNT_W-1:0] limit;
    logic [TCNT_W-1:0] tcnt_inc;
    logic              hit_to;

    always_comb begin
        eff_max  = (max_i == '0) ? CNT_W'(1) : max_i;
        limit    = TCNT_W'(eff_max) * TCNT_W'(thr_i);
        tcnt_inc = q.tcnt + TCNT_W'(1);
        scnt_inc = q.scnt + CNT_W'(1);
        hit_to   = (tcnt_inc >= limit);

        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (cyc_en_i && !q.timeout) begin
                    d.st   = ST_ARM;
                    d.tcnt = '0;
                end
            end
            ST_ARM: begin
                d.tcnt = tcnt_inc;
                if (rise_i) begin
                    d.st   = ST_COUNT;
                    d.rcnt = '0;
                    d.scnt = '0;
                end else if (hit_to) begin
                    d.st      = ST_IDLE;
                    d.timeout = 1'b1;
                    d.ready   = 1'b0;
                    d.tcnt    = '0;
                end
            end
            ST_COUNT: begin
                d.tcnt = tcnt_inc;
                d.rcnt = q.rcnt + TCNT_W'(1);
                if (rise_i && (scnt_inc == eff_max)) begin
                    // completion wins over a coincident timeout
                    d.result = q.rcnt + TCNT_W'(1);
                    d.ready  = 1'b1;
                    d.rcnt   = '0;
                    d.scnt   = '0;
                    d.tcnt   = '0;
                    d.st     = cyc_en_i ? ST_COUNT : ST_IDLE;
                end else if (hit_to) begin
                    d.st      = ST_IDLE;
                    d.timeout = 1'b1;
                    d.ready   = 1'b0;
                    d.rcnt    = '0;
                    d.scnt    = '0;
                    d.tcnt    = '0;
                end else if (rise_i) begin
                    d.scnt = scnt_inc;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (start_pulse_i) begin
            d.st      = ST_ARM;
            d.ready   = 1'b0;
            d.timeout = 1'b0;
            d.rcnt    = '0;
            d.scnt    = '0;
            d.tcnt    = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st      <= ST_IDLE;
            q.ready   <= 1'b0;
            q.timeout <= 1'b0;
            q.scnt    <= '0;
            q.rcnt    <= '0;
            q.tcnt    <= '0;
            q.result  <= '0;
        end else begin
            q <= d;
        end
    end

    assign ready_o   = q.ready;
    assign timeout_o = q.timeout;
    assign busy_o    = (q.st != ST_IDLE);
    assign result_o  = q.result;

endmodule

// File: rtl/slowcal_top.sv
module slowcal_top #(
    parameter int NSRC    = 3,
    parameter int DATA_W  = 32,
    parameter int CNT_W   = 10,
    parameter int THR_W   = 16,
    parameter int RST_MAX = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   slow_src_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [1:0]        rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam int SEL_W = $clog2(NSRC + 1);
    localparam int RES_W = CNT_W + THR_W;

    logic [SEL_W-1:0] sel;
    logic [CNT_W-1:0] maxc;
    logic [THR_W-1:0] thr;
    logic             cyc_en;
    logic             start_pulse;
    logic             slow_rise;
    logic             ready;
    logic             timeout;
    logic             busy;
    logic [RES_W-1:0] result;

    slowcal_sync #(
        .NSRC  (NSRC),
        .SEL_W (SEL_W)
    ) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (slow_src_i),
        .sel_i  (sel),
        .rise_o (slow_rise)
    );

    slowcal_regs #(
        .DATA_W  (DATA_W),
        .SEL_W   (SEL_W),
        .CNT_W   (CNT_W),
        .THR_W   (THR_W),
        .RES_W   (RES_W),
        .RST_MAX (RST_MAX)
    ) regs_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en_i       (wr_en_i),
        .wr_addr_i     (wr_addr_i),
        .wr_data_i     (wr_data_i),
        .rd_addr_i     (rd_addr_i),
        .rd_data_o     (rd_data_o),
        .ready_i       (ready),
        .timeout_i     (timeout),
        .busy_i        (busy),
        .result_i      (result),
        .sel_o         (sel),
        .max_o         (maxc),
        .thr_o         (thr),
        .cyc_en_o      (cyc_en),
        .start_pulse_o (start_pulse)
    );

    slowcal_engine #(
        .CNT_W (CNT_W),
        .THR_W (THR_W)
    ) eng_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .rise_i        (slow_rise),
        .start_pulse_i (start_pulse),
        .cyc_en_i      (cyc_en),
        .max_i         (maxc),
        .thr_i         (thr),
        .ready_o       (ready),
        .timeout_o     (timeout),
        .busy_o        (busy),
        .result_o      (result)
    );

endmodule

// File: rtl/slowcal_chk.sv
module slowcal_chk #(
    parameter int DATA_W = 32,
    parameter int RES_W  = 26
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_pulse,
    input logic              slow_rise,
    input logic              ready,
    input logic              timeout,
    input logic              busy,
    input logic              cyc_en,
    input logic [RES_W-1:0]  result,
    input logic [1:0]        rd_addr_i,
    input logic [DATA_W-1:0] rd_data_o
);

    assert_ready_on_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(slow_rise));

    assert_start_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> (!ready && !timeout));

    assert_result_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !busy && !cyc_en && !start_pulse) |=> $stable(result));

    assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> !ready);

    assert_zero_on_timeout_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout && rd_addr_i == 2'd3) |-> (rd_data_o == '0));

    assert_timeout_idles_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> !busy);

endmodule

bind slowcal_top slowcal_chk #(
    .DATA_W (DATA_W),
    .RES_W  (RES_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_pulse (start_pulse),
    .slow_rise   (slow_rise),
    .ready       (ready),
    .timeout     (timeout),
    .busy        (busy),
    .cyc_en      (cyc_en),
    .result      (result),
    .rd_addr_i   (rd_addr_i),
    .rd_data_o   (rd_data_o)
);

// File: tb/slowcal_top_tb_top.sv
`timescale 1ns/1ps
module slowcal_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  slow_src = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    int half [3];
    int cnt  [3];

    always #5 clk = ~clk;

    slowcal_top dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .slow_src_i (slow_src),
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data),
        .rd_addr_i  (rd_addr),
        .rd_data_o  (rd_data)
    );

    // slow clock generators: each toggles every half[i] reference cycles
    always @(negedge clk) begin
        for (int i = 0; i < 3; i++) begin
            if (half[i] == 0) begin
                slow_src[i] <= 1'b0;
                cnt[i]      <= 0;
            end else if (cnt[i] >= half[i] - 1) begin
                slow_src[i] <= ~slow_src[i];
                cnt[i]      <= 0;
            end else begin
                cnt[i] <= cnt[i] + 1;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        rd_addr = a;
        #1 v = rd_data;
    endtask

    function automatic logic [31:0] ctrl(input int sel, input bit start, input bit cyc);
        logic [31:0] c;
        c = '0;
        c[1:0] = 2'(sel);
        c[2] = start;
        c[3] = cyc;
        return c;
    endfunction

    task automatic launch(input int sel, input bit cyc);
        wr(2'd0, ctrl(sel, 1'b0, cyc));
        wr(2'd0, ctrl(sel, 1'b1, cyc));
    endtask

    task automatic wait_ready(input int bound, output bit ok);
        logic [31:0] v;
        ok = 1'b0;
        for (int k = 0; k < bound; k++) begin
            @(negedge clk);
            rd(2'd0, v);
            if (v[4]) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    task automatic t_reset();
        logic [31:0] v;
        @(negedge clk);
        rd(2'd0, v);
        chk("R1 cycle enable", 32'(v[3]), 32'd1);
        chk("R1 ready", 32'(v[4]), 32'd0);
        chk("R1 timeout", 32'(v[5]), 32'd0);
        rd(2'd1, v); chk("R1 count", v, 32'd8);
        rd(2'd2, v); chk("R1 threshold", v, 32'hFFFF);
        rd(2'd3, v); chk("R1 result", v, 32'd0);
        // cycling from reset, source 0, P=10, N=8
        repeat (300) @(posedge clk);
        @(negedge clk);
        rd(2'd0, v); chk("R6 ready from reset", 32'(v[4]), 32'd1);
        rd(2'd3, v); chk("R6 reset cycling result", v, 32'd80);
    endtask

    task automatic t_oneshot();
        logic [31:0] v;
        bit ok;
        wr(2'd0, ctrl(0, 1'b0, 1'b0));
        wr(2'd1, 32'd4);
        wr(2'd0, ctrl(0, 1'b1, 1'b0));
        @(negedge clk);
        rd(2'd0, v);
        chk("R4 ready cleared", 32'(v[4]), 32'd0);
        wait_ready(5 * 10 + 20, ok);
        chk("R2 ready set", 32'(ok), 32'd1);
        rd(2'd3, v); chk("R2 result N*P", v, 32'd40);
    endtask

    task automatic t_level_start();
        logic [31:0] v;
        wr(2'd0, ctrl(0, 1'b1, 1'b0));
        @(negedge clk);
        rd(2'd0, v); chk("R3 ready kept", 32'(v[4]), 32'd1);
        rd(2'd3, v); chk("R3 result kept", v, 32'd40);
    endtask

    task automatic t_stops();
        logic [31:0] v;
        half[0] = 7;
        repeat (200) @(posedge clk);
        @(negedge clk);
        rd(2'd0, v); chk("R5 idle", 32'(v[6]), 32'd0);
        rd(2'd3, v); chk("R5 result frozen", v, 32'd40);
    endtask

    task automatic t_select();
        logic [31:0] v;
        bit ok;
        launch(1, 1'b0);
        wait_ready(5 * 14 + 20, ok);
        rd(2'd3, v); chk("R7 source 1", v, 32'd56);
        launch(2, 1'b0);
        wait_ready(5 * 6 + 20, ok);
        rd(2'd3, v); chk("R7 source 2", v, 32'd24);
    endtask

    task automatic t_zero_count();
        logic [31:0] v;
        bit ok;
        wr(2'd1, 32'd0);
        launch(2, 1'b0);
        wait_ready(2 * 6 + 20, ok);
        chk("R11 ready", 32'(ok), 32'd1);
        rd(2'd3, v); chk("R11 count zero as one", v, 32'd6);
    endtask

    task automatic t_timeout();
        logic [31:0] v;
        // N=2, T=5 -> limit 10 cycles, no source selected
        wr(2'd1, 32'd2);
        wr(2'd2, 32'd5);
        wr(2'd0, ctrl(3, 1'b0, 1'b0));
        wr(2'd0, ctrl(3, 1'b1, 1'b0));
        repeat (9) @(posedge clk);
        @(negedge clk);
        rd(2'd0, v); chk("R8 no timeout before limit", 32'(v[5]), 32'd0);
        @(negedge clk);
        rd(2'd0, v);
        chk("R8 timeout at limit", 32'(v[5]), 32'd1);
        chk("R8 ready low", 32'(v[4]), 32'd0);
        repeat (20) @(posedge clk);
        @(negedge clk);
        rd(2'd0, v); chk("R8 idle after timeout", 32'(v[6]), 32'd0);
        rd(2'd3, v); chk("R8 result zero", v, 32'd0);
    endtask

    task automatic t_recover();
        logic [31:0] v;
        bit ok;
        wr(2'd2, 32'hFFFF);
        wr(2'd1, 32'd3);
        wr(2'd0, ctrl(0, 1'b0, 1'b0));
        wr(2'd0, ctrl(0, 1'b1, 1'b0));
        @(negedge clk);
        rd(2'd0, v); chk("R4 timeout cleared", 32'(v[5]), 32'd0);
        wait_ready(4 * 14 + 20, ok);
        rd(2'd3, v); chk("R9 clean result", v, 32'd42);
    endtask

    task automatic t_cycling();
        logic [31:0] v;
        bit ok;
        half[0] = 5;
        wr(2'd1, 32'd4);
        launch(0, 1'b1);
        wait_ready(5 * 10 + 30, ok);
        rd(2'd3, v); chk("R6 cycling result", v, 32'd40);
        half[0] = 4;
        repeat (3 * 40 + 30) @(posedge clk);
        @(negedge clk);
        rd(2'd3, v); chk("R6 tracks new period", v, 32'd32);
        rd(2'd0, v); chk("R6 still running", 32'(v[6]), 32'd1);
    endtask

    task automatic t_abort();
        logic [31:0] v;
        wr(2'd1, 32'd8);
        launch(3, 1'b1);
        repeat (500) @(posedge clk);
        @(negedge clk);
        rd(2'd0, v);
        chk("R10 running before abort", 32'(v[6]), 32'd1);
        chk("R10 no early timeout", 32'(v[5]), 32'd0);
        wr(2'd2, 32'd1);
        @(posedge clk);
        @(negedge clk);
        rd(2'd0, v); chk("R10 timeout next edge", 32'(v[5]), 32'd1);
        repeat (50) @(posedge clk);
        @(negedge clk);
        rd(2'd0, v); chk("R10 stopped", 32'(v[6]), 32'd0);
    endtask

    initial begin
        half[0] = 5; half[1] = 7; half[2] = 3;
        cnt[0] = 0; cnt[1] = 0; cnt[2] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_oneshot();
        t_level_start();
        t_stops();
        t_select();
        t_zero_count();
        t_timeout();
        t_recover();
        t_cycling();
        t_abort();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule